// File: doc/BRIEF.md
# Masked Field-Match Sticky Alarm

This block watches a set of live calendar fields (seconds, minutes, hours, day of month, month, day of week and year, each an 8-bit BCD byte) and raises a sticky alarm flag when every field selected by an enable mask equals its programmed threshold. It holds the enable mask and seven threshold bytes. A host interface that has already been decoded writes and reads these registers through a select code, a write strobe and a read strobe.

The compare runs only in the cycle in which the time base pulses its seconds tick. The time base is expected to present the updated field values in that same cycle. Once the flag is set, it stays set until the host reads or writes any of the alarm registers. The host polls the flag through the minutes read value, where it takes the place of the top bit.

Top module: `field_match_alarm`

## Requirements
- R1: After reset the enable mask reads 00h and the thresholds read seconds 7Fh, minutes 7Fh, hours BFh, date 3Fh, month 1Fh, weekday 07h and year FFh. The alarm flag reads 0.
- R2: Select codes 0 to 6 address the thresholds for seconds, minutes, hours, date, month, weekday and year, in that order. Code 7 addresses the enable mask. A write stores the byte at the clock edge, and `host_rdata` shows the selected register without a strobe. Mask bit 7 is not stored and always reads 0.
- R3: Mask bit i (i = 0..6) enables the compare of field i, using the field order of R2. A mismatch on a field whose bit is clear has no effect.
- R4: The flag is set at the clock edge of a cycle with `sec_tick` high, and only then, when every enabled field equals its threshold. It reads 1 from the next cycle on.
- R5: With a mask of zero the flag never sets, even when all fields match.
- R6: Once set, the flag stays 1 across later ticks, whether they match or not, until a read or write strobe to any select code clears it at the next edge.
- R7: When a read or write strobe and a matching tick occur in the same cycle, the flag ends up 0.
- R8: `minutes_rd` equals the live minutes byte with bit 7 replaced by the alarm flag.
- R9: With a mask of 0000_0011, the flag sets only when seconds and minutes both match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse marking freshly updated time fields |
| live_time | input | 56 | Live fields, byte i = field i (0 seconds .. 6 year) |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_sel | input | 3 | Register select code (0..6 thresholds, 7 mask) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Contents of the selected register |
| alarm_flag | output | 1 | Sticky alarm flag |
| minutes_rd | output | 8 | Minutes read value with the flag in bit 7 |

## Verification
The bench uses the default build of seven 8-bit fields. At that size all 127 non-zero enable masks can be swept. For each mask it runs a full match and a single-field mismatch on every field in turn, so the mapping from each mask bit to its field and the all-enabled-must-match rule are covered for every combination. It also covers the mask-zero case, strobe-versus-tick collisions, clears by reads and writes to both mask and threshold codes, and the minutes readback.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int unsigned NUM_FIELDS = 7;
    localparam int unsigned FIELD_W    = 8;
    localparam int unsigned SEL_W      = $clog2(NUM_FIELDS + 1);
    localparam int unsigned TIME_W     = NUM_FIELDS * FIELD_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC   = 3'd0,
        SEL_MIN   = 3'd1,
        SEL_HOUR  = 3'd2,
        SEL_DATE  = 3'd3,
        SEL_MONTH = 3'd4,
        SEL_WDAY  = 3'd5,
        SEL_YEAR  = 3'd6,
        SEL_MASK  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic               wr;
        logic               rd;
        logic [SEL_W-1:0]   sel;
        logic [FIELD_W-1:0] wdata;
    } host_req_t;

    // Power-up value of each threshold byte.
    function automatic logic [FIELD_W-1:0] thr_reset(input int unsigned idx);
        logic [FIELD_W-1:0] v;
        case (idx)
            0:       v = 8'h7F;
            1:       v = 8'h7F;
            2:       v = 8'hBF;
            3:       v = 8'h3F;
            4:       v = 8'h1F;
            5:       v = 8'h07;
            6:       v = 8'hFF;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic host_touch(input host_req_t r);
        return r.wr | r.rd;
    endfunction

endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
    import alarm_pkg::*;
#(
    parameter int unsigned NF = NUM_FIELDS,
    parameter int unsigned W  = FIELD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  host_req_t       req,
    output logic [NF-1:0]   en_mask,
    output logic [NF*W-1:0] thr_flat,
    output logic [W-1:0]    rd_data
);
    localparam int unsigned PAD_W = W - NF;

    logic [W-1:0]  thr_q [NF];
    logic [NF-1:0] mask_q;

    for (genvar g = 0; g < NF; g++) begin : g_thr
        always_ff @(posedge clk) begin
            if (rst) begin
                thr_q[g] <= thr_reset(g);
            end else if (req.wr && (req.sel == SEL_W'(g))) begin
                thr_q[g] <= req.wdata;
            end
        end
        assign thr_flat[g*W +: W] = thr_q[g];
    end

    // The top bit of the written byte is dropped; only field enables are kept.
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (req.wr && (req.sel == SEL_MASK)) begin
            mask_q <= req.wdata[NF-1:0];
        end
    end

    assign en_mask = mask_q;

    always_comb begin
        rd_data = '0;
        if (req.sel == SEL_MASK) begin
            rd_data = {{PAD_W{1'b0}}, mask_q};
        end else if (int'(req.sel) < int'(NF)) begin
            rd_data = thr_q[req.sel];
        end
    end

endmodule

// File: rtl/field_compare.sv
module field_compare
    import alarm_pkg::*;
#(
    parameter int unsigned NF = NUM_FIELDS,
    parameter int unsigned W  = FIELD_W
) (
    input  logic [NF*W-1:0] live_flat,
    input  logic [NF*W-1:0] thr_flat,
    input  logic [NF-1:0]   en_mask,
    output logic [NF-1:0]   hit_vec,
    output logic            all_match
);
    logic [NF-1:0] pass_vec;

    for (genvar g = 0; g < NF; g++) begin : g_cmp
        assign hit_vec[g]  = (live_flat[g*W +: W] == thr_flat[g*W +: W]);
        assign pass_vec[g] = hit_vec[g] | ~en_mask[g];
    end

    // An empty mask never qualifies.
    assign all_match = (|en_mask) & (&pass_vec);

endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clear,
    input  logic match,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (clear) begin
            flag <= 1'b0;
        end else if (tick && match) begin
            flag <= 1'b1;
        end
    end
endmodule

// File: rtl/field_match_alarm.sv
module field_match_alarm
    import alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sec_tick,
    input  logic [TIME_W-1:0]  live_time,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [SEL_W-1:0]   host_sel,
    input  logic [FIELD_W-1:0] host_wdata,
    output logic [FIELD_W-1:0] host_rdata,
    output logic               alarm_flag,
    output logic [FIELD_W-1:0] minutes_rd
);
    host_req_t             req;
    logic [NUM_FIELDS-1:0] en_mask;
    logic [TIME_W-1:0]     thr_flat;
    logic [NUM_FIELDS-1:0] hit_vec;
    logic                  all_match;

    assign req = '{wr: host_wr, rd: host_rd, sel: host_sel, wdata: host_wdata};

    alarm_regfile #(.NF(NUM_FIELDS), .W(FIELD_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .en_mask  (en_mask),
        .thr_flat (thr_flat),
        .rd_data  (host_rdata)
    );

    field_compare #(.NF(NUM_FIELDS), .W(FIELD_W)) u_cmp (
        .live_flat (live_time),
        .thr_flat  (thr_flat),
        .en_mask   (en_mask),
        .hit_vec   (hit_vec),
        .all_match (all_match)
    );

    alarm_flag_ctl u_flag (
        .clk   (clk),
        .rst   (rst),
        .tick  (sec_tick),
        .clear (host_touch(req)),
        .match (all_match),
        .flag  (alarm_flag)
    );

    assign minutes_rd = {alarm_flag, live_time[int'(SEL_MIN)*FIELD_W +: FIELD_W-1]};

endmodule

// File: rtl/field_match_alarm_chk.sv
module field_match_alarm_chk
    import alarm_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  sec_tick,
    input logic                  host_wr,
    input logic                  host_rd,
    input logic                  alarm_flag,
    input logic [FIELD_W-1:0]    minutes_rd,
    input logic [FIELD_W-1:0]    live_min,
    input logic [NUM_FIELDS-1:0] en_mask,
    input logic                  all_match
);
    a_r4_tick_only: assert property (@(posedge clk) disable iff (rst)
        (!alarm_flag && !sec_tick) |=> !alarm_flag);

    a_r4_sets_on_match: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && all_match && !host_wr && !host_rd) |=> alarm_flag);

    a_r5_empty_mask: assert property (@(posedge clk) disable iff (rst)
        (!alarm_flag && en_mask == '0) |=> !alarm_flag);

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !host_wr && !host_rd) |=> alarm_flag);

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (host_wr || host_rd) |=> !alarm_flag);

    always @(posedge clk) begin
        if (!rst) begin
            a_r8_minutes_view: assert (minutes_rd == {alarm_flag, live_min[FIELD_W-2:0]});
        end
    end
endmodule

bind field_match_alarm field_match_alarm_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sec_tick   (sec_tick),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .alarm_flag (alarm_flag),
    .minutes_rd (minutes_rd),
    .live_min   (live_time[15:8]),
    .en_mask    (en_mask),
    .all_match  (all_match)
);

// File: tb/tb_field_match_alarm.sv
module tb_field_match_alarm;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic [55:0] live_time = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [2:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        alarm_flag;
    logic [7:0]  minutes_rd;

    int checks = 0;
    int errors = 0;

    logic [7:0] defaults [7] = '{8'h7F, 8'h7F, 8'hBF, 8'h3F, 8'h1F, 8'h07, 8'hFF};

    always #(CLK_PERIOD/2) clk = ~clk;

    field_match_alarm dut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .live_time(live_time),
        .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .alarm_flag(alarm_flag), .minutes_rd(minutes_rd)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] sel);
        @(negedge clk);
        host_rd = 1'b1; host_sel = sel;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    function automatic logic [55:0] pack_default(input int flip);
        logic [55:0] v;
        for (int i = 0; i < 7; i++) v[i*8 +: 8] = (i == flip) ? (defaults[i] ^ 8'h01) : defaults[i];
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state seen through the readback path
        for (int s = 0; s < 7; s++) begin
            host_sel = 3'(s); #1;
            chk(host_rdata == defaults[s], "R1 threshold reset", host_rdata, defaults[s]);
        end
        host_sel = 3'd7; #1;
        chk(host_rdata == 8'h00, "R1 mask reset", host_rdata, 8'h00);
        chk(alarm_flag == 1'b0, "R1 flag reset", {7'd0, alarm_flag}, 8'h00);

        // R5: empty mask with every field matching
        live_time = pack_default(7);
        do_tick();
        chk(alarm_flag == 1'b0, "R5 empty mask", {7'd0, alarm_flag}, 8'h00);

        // R4: a full match with no tick leaves the flag clear
        do_write(3'd7, 8'h7F);
        repeat (4) @(negedge clk);
        chk(alarm_flag == 1'b0, "R4 no tick", {7'd0, alarm_flag}, 8'h00);

        // R3/R4/R9: sweep every non-zero mask against each single-field mismatch
        for (int m = 1; m < 128; m++) begin
            for (int f = 0; f < 8; f++) begin
                bit exp;
                do_write(3'd7, 8'(m));
                live_time = pack_default(f);
                do_tick();
                exp = (f == 7) || !m[f];
                if (m == 3)
                    chk(alarm_flag == exp, "R9 seconds+minutes mask", {7'd0, alarm_flag}, {7'd0, exp});
                else if (f == 7)
                    chk(alarm_flag == exp, "R4 full match", {7'd0, alarm_flag}, {7'd0, exp});
                else
                    chk(alarm_flag == exp, "R3 field enable", {7'd0, alarm_flag}, {7'd0, exp});
            end
        end

        // R2: writes land in the addressed register, mask bit 7 is dropped
        for (int s = 0; s < 7; s++) begin
            do_write(3'(s), 8'(8'h11 * (s + 1)));
        end
        for (int s = 0; s < 7; s++) begin
            host_sel = 3'(s); #1;
            chk(host_rdata == 8'(8'h11 * (s + 1)), "R2 threshold write", host_rdata, 8'(8'h11 * (s + 1)));
        end
        do_write(3'd7, 8'hFF);
        host_sel = 3'd7; #1;
        chk(host_rdata == 8'h7F, "R2 mask bit 7 ignored", host_rdata, 8'h7F);

        // R6: set, then stays through mismatching ticks
        do_write(3'd7, 8'h02);
        live_time = '0;
        live_time[15:8] = 8'h22;
        do_tick();
        chk(alarm_flag == 1'b1, "R6 set", {7'd0, alarm_flag}, 8'h01);
        live_time[15:8] = 8'h59;
        do_tick(); do_tick();
        chk(alarm_flag == 1'b1, "R6 holds over mismatch", {7'd0, alarm_flag}, 8'h01);
        // R8: flag appears in minutes readback top bit
        chk(minutes_rd == 8'hD9, "R8 minutes view set", minutes_rd, 8'hD9);
        do_read(3'd4);
        chk(alarm_flag == 1'b0, "R6 read of threshold clears", {7'd0, alarm_flag}, 8'h00);
        chk(minutes_rd == 8'h59, "R8 minutes view clear", minutes_rd, 8'h59);

        live_time[15:8] = 8'h22;
        do_tick();
        chk(alarm_flag == 1'b1, "R6 set again", {7'd0, alarm_flag}, 8'h01);
        do_read(3'd7);
        chk(alarm_flag == 1'b0, "R6 read of mask clears", {7'd0, alarm_flag}, 8'h00);
        do_tick();
        do_write(3'd0, 8'h11);
        chk(alarm_flag == 1'b0, "R6 write of threshold clears", {7'd0, alarm_flag}, 8'h00);

        // R7: strobe and matching tick in the same cycle
        @(negedge clk);
        sec_tick = 1'b1; host_rd = 1'b1; host_sel = 3'd2;
        @(negedge clk);
        sec_tick = 1'b0; host_rd = 1'b0;
        chk(alarm_flag == 1'b0, "R7 clear beats match", {7'd0, alarm_flag}, 8'h00);
        do_tick();
        @(negedge clk);
        sec_tick = 1'b1; host_wr = 1'b1; host_sel = 3'd5; host_wdata = 8'h03;
        @(negedge clk);
        sec_tick = 1'b0; host_wr = 1'b0;
        chk(alarm_flag == 1'b0, "R7 write beats match", {7'd0, alarm_flag}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule